// File: doc/BRIEF.md
# Tagged Circular Floating-Point Register Stack

This block holds eight 64-bit floating-point registers arranged as a ring, addressed through a 3-bit top-of-stack pointer. Every register carries its own occupancy tag, so occupancy is tracked per register and not as a depth count. A caller issues one operation per cycle through a valid strobe, an operation code, a relative index `i` and write data. The block returns read data and two fault flags one cycle later.

Relative references resolve to physical register `(top + i) mod 8`. Push moves the pointer down before it writes. Pop reads at the pointer and then moves it up. Reading or modifying an empty register raises an empty fault. Writing into an occupied register raises a full fault. Two operations are exempt. An examine read never raises the empty fault. A copy from the top register into `ST(i)` never raises the full fault. An operation that faults changes nothing. The current pointer and the tag vector are visible on output ports. Arithmetic, rounding and any fault recovery belong to the surrounding datapath.

Top module: `fp_tag_stack`

## Requirements
- R1: After reset all tags read 0 (empty), the top pointer reads 0, every data register holds zero, and `rd_data`, `rd_vld`, `flt_empty` and `flt_full` are 0.
- R2: A push targets physical register `(top-1) mod 8`. If that register's tag is set, `flt_full` is raised. Otherwise the pointer becomes `(top-1) mod 8`, `wr_data` is stored there and its tag is set.
- R3: A pop reads the register at `top`. If its tag is clear, `flt_empty` is raised. Otherwise its contents appear on `rd_data` with `rd_vld`, its tag is cleared and the pointer becomes `(top+1) mod 8`.
- R4: Read, write, modify, examine, copy destination and free all address physical register `(top + rel_idx) mod 8`, wrapping around the ring.
- R5: A read or a modify of an empty register raises `flt_empty`. A write to an occupied register raises `flt_full`. A successful modify returns the old value on `rd_data` and stores `wr_data` in its place.
- R6: An examine never raises a fault. It returns the register contents on `rd_data` with `rd_vld` whether the tag is set or clear.
- R7: A copy stores the contents of ST(0) into ST(i) and sets that tag, even when the destination is already occupied, without raising `flt_full`. If ST(0) is empty it raises `flt_empty` and changes nothing.
- R8: A free clears the tag of ST(i). It does not move the pointer and never faults.
- R9: An operation that raises a fault leaves every register, tag and the pointer unchanged. Each faulting operation produces exactly one cycle of its fault flag, and back-to-back faulting operations produce one pulse each.
- R10: Operation codes on `op_code` are: 0 push, 1 pop, 2 read, 3 write, 4 modify, 5 examine, 6 copy, 7 free. Results for an operation presented at a clock edge appear on the outputs after that edge and last one cycle. `rd_data` is zero whenever `rd_vld` is 0, and all result outputs are zero in a cycle with no valid operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_vld | input | 1 | Operation valid strobe |
| op_code | input | 3 | Operation select (see R10) |
| rel_idx | input | 3 | Relative register index i |
| wr_data | input | 64 | Data for push, write and modify |
| rd_data | output | 64 | Read result, zero when not valid |
| rd_vld | output | 1 | Read result valid |
| flt_empty | output | 1 | Register-empty fault pulse |
| flt_full | output | 1 | Register-full fault pulse |
| top_o | output | 3 | Current top pointer |
| tag_o | output | 8 | Occupancy tag per physical register |

## Verification
The pointer and the tag vector are on ports, so a wrong pointer step or a lost or stray tag shows in the cycle after the operation that caused it. A corrupted data register stays hidden until it is read back. The bench therefore reads every register through pops, reads and examines, including examines of empty entries. A wrong fault decision shows as a flag on the wrong cycle, or as a state change after a fault.

// File: rtl/fp_tag_stack.sv
module fp_tag_stack #(
  parameter int W  = 64,
  parameter int N  = 8,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_vld,
  input  logic [2:0]    op_code,
  input  logic [PW-1:0] rel_idx,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic          rd_vld,
  output logic          flt_empty,
  output logic          flt_full,
  output logic [PW-1:0] top_o,
  output logic [N-1:0]  tag_o
);
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_READ = 3'd2, OP_WRITE = 3'd3,
                         OP_MOD  = 3'd4, OP_EXAM = 3'd5, OP_COPY = 3'd6, OP_FREE = 3'd7;

  logic [W-1:0]  regs [N];
  logic          tag_q [N];
  logic [PW-1:0] top_q;

  wire [PW-1:0] rel_a  = top_q + rel_idx;
  wire [PW-1:0] push_a = top_q - 1'b1;
  wire          at_top = (op_code == OP_POP) || (op_code == OP_COPY);
  wire [PW-1:0] src_a  = at_top ? top_q : rel_a;
  wire [PW-1:0] dst_a  = (op_code == OP_PUSH) ? push_a : rel_a;

  wire need_full  = (op_code == OP_PUSH) || (op_code == OP_WRITE);
  wire need_empty = (op_code == OP_POP) || (op_code == OP_READ) ||
                    (op_code == OP_MOD) || (op_code == OP_COPY);

  wire e_flt = op_vld && need_empty && !tag_q[src_a];
  wire f_flt = op_vld && need_full && tag_q[dst_a];
  wire ok    = op_vld && !e_flt && !f_flt;

  wire wr_en  = ok && (need_full || (op_code == OP_MOD) || (op_code == OP_COPY));
  wire clr_en = ok && ((op_code == OP_POP) || (op_code == OP_FREE));
  wire [PW-1:0] clr_a = (op_code == OP_POP) ? top_q : rel_a;
  wire [W-1:0]  wr_val = (op_code == OP_COPY) ? regs[src_a] : wr_data;
  wire rd_en = ok && ((op_code == OP_POP) || (op_code == OP_READ) ||
                      (op_code == OP_MOD) || (op_code == OP_EXAM));

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g]  <= '0;
        tag_q[g] <= 1'b0;
      end else if (wr_en && dst_a == PW'(g)) begin
        regs[g]  <= wr_val;
        tag_q[g] <= 1'b1;
      end else if (clr_en && clr_a == PW'(g)) begin
        tag_q[g] <= 1'b0;
      end
    end
    assign tag_o[g] = tag_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q     <= '0;
      rd_data   <= '0;
      rd_vld    <= 1'b0;
      flt_empty <= 1'b0;
      flt_full  <= 1'b0;
    end else begin
      if (ok && op_code == OP_PUSH)     top_q <= push_a;
      else if (ok && op_code == OP_POP) top_q <= top_q + 1'b1;
      rd_vld    <= rd_en;
      rd_data   <= rd_en ? regs[src_a] : '0;
      flt_empty <= e_flt;
      flt_full  <= f_flt;
    end
  end

  assign top_o = top_q;
endmodule

// File: rtl/fp_tag_stack_chk.sv
module fp_tag_stack_chk #(
  parameter int W  = 64,
  parameter int N  = 8,
  localparam int PW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_vld,
  input logic [2:0]    op_code,
  input logic [W-1:0]  rd_data,
  input logic          rd_vld,
  input logic          flt_empty,
  input logic          flt_full,
  input logic [PW-1:0] top_o,
  input logic [N-1:0]  tag_o
);
  AST_ONE_FAULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_empty && flt_full)); // R9
  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_empty || flt_full) |-> (top_o == $past(top_o) && tag_o == $past(tag_o))); // R9
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_code == 3'd0 && !tag_o[PW'(top_o - 1'b1)])
      |=> (top_o == PW'($past(top_o) - 1'b1) && tag_o[top_o])); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_code == 3'd1 && tag_o[top_o])
      |=> (top_o == PW'($past(top_o) + 1'b1) && rd_vld)); // R3
  AST_EXAM_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_code == 3'd5) |=> (!flt_empty && rd_vld)); // R6
  AST_COPY_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_code == 3'd6) |=> !flt_full); // R7
  AST_FREE_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_code == 3'd7) |=> (top_o == $past(top_o) && !flt_empty && !flt_full)); // R8
  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |-> (rd_data == '0)); // R10
endmodule

bind fp_tag_stack fp_tag_stack_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code),
  .rd_data(rd_data), .rd_vld(rd_vld), .flt_empty(flt_empty), .flt_full(flt_full),
  .top_o(top_o), .tag_o(tag_o)
);

// File: tb/fp_tag_stack_tb.sv
module fp_tag_stack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_vld = 1'b0;
  logic [2:0]  op_code = '0;
  logic [2:0]  rel_idx = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        rd_vld, flt_empty, flt_full;
  logic [2:0]  top_o;
  logic [7:0]  tag_o;

  fp_tag_stack dut_i (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m_reg [8];
  bit   [7:0]  m_tag;
  int          m_top;
  logic [63:0] e_rd;
  bit          e_rv, e_fe, e_ff;

  task automatic check(string req);
    checks++;
    if (rd_data !== e_rd || rd_vld !== e_rv || flt_empty !== e_fe || flt_full !== e_ff ||
        top_o !== 3'(m_top) || tag_o !== m_tag) begin
      errors++;
      $display("FAIL %s: got rd=%h v=%0b fe=%0b ff=%0b top=%0d tag=%b exp rd=%h v=%0b fe=%0b ff=%0b top=%0d tag=%b",
               req, rd_data, rd_vld, flt_empty, flt_full, top_o, tag_o,
               e_rd, e_rv, e_fe, e_ff, m_top, m_tag);
    end
  endtask

  task automatic model(bit v, int op, int i, logic [63:0] d);
    int r = (m_top + i) % 8;
    e_rd = '0; e_rv = 0; e_fe = 0; e_ff = 0;
    if (!v) return;
    case (op)
      0: begin
        int p = (m_top + 7) % 8;
        if (m_tag[p]) e_ff = 1;
        else begin m_top = p; m_reg[p] = d; m_tag[p] = 1; end
      end
      1: if (!m_tag[m_top]) e_fe = 1;
         else begin e_rv = 1; e_rd = m_reg[m_top]; m_tag[m_top] = 0; m_top = (m_top + 1) % 8; end
      2: if (!m_tag[r]) e_fe = 1; else begin e_rv = 1; e_rd = m_reg[r]; end
      3: if (m_tag[r]) e_ff = 1; else begin m_reg[r] = d; m_tag[r] = 1; end
      4: if (!m_tag[r]) e_fe = 1;
         else begin e_rv = 1; e_rd = m_reg[r]; m_reg[r] = d; end
      5: begin e_rv = 1; e_rd = m_reg[r]; end
      6: if (!m_tag[m_top]) e_fe = 1; else begin m_reg[r] = m_reg[m_top]; m_tag[r] = 1; end
      default: m_tag[r] = 0;
    endcase
  endtask

  task automatic do_op(bit v, int op, int i, logic [63:0] d, string req);
    op_vld = v; op_code = 3'(op); rel_idx = 3'(i); wr_data = d;
    model(v, op, i, d);
    @(negedge clk);
    check(req);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) m_reg[k] = '0;
    m_tag = '0; m_top = 0;
    e_rd = '0; e_rv = 0; e_fe = 0; e_ff = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");
    do_op(1, 5, 3, 0, "R1 R6 examine after reset");
    do_op(1, 1, 0, 0, "R3 pop of empty");
    do_op(1, 1, 0, 0, "R9 second faulting pop");
    do_op(0, 0, 0, 0, "R10 idle cycle");
    do_op(1, 2, 0, 0, "R5 read empty");
    do_op(1, 0, 0, 64'hAAAA_0000_0000_0001, "R2 push wraps to 7");
    do_op(1, 0, 0, 64'hBBBB_0000_0000_0002, "R2 second push");
    do_op(1, 2, 1, 0, "R4 read ST1");
    do_op(1, 3, 2, 64'hCCCC_0000_0000_0003, "R4 R5 write ST2 wraps to 0");
    do_op(1, 3, 0, 64'hDEAD, "R5 R9 write occupied");
    do_op(1, 4, 2, 64'hDDDD_0000_0000_0004, "R5 modify returns old");
    do_op(1, 2, 2, 0, "R5 read after modify");
    do_op(1, 6, 1, 0, "R7 copy onto occupied");
    do_op(1, 2, 1, 0, "R7 copied value");
    do_op(1, 7, 1, 0, "R8 free ST1");
    do_op(1, 2, 1, 0, "R8 read freed reg");
    do_op(1, 5, 1, 0, "R6 examine freed reg");
    do_op(1, 6, 3, 0, "R7 copy to empty");
    do_op(1, 1, 0, 0, "R3 pop");
    do_op(1, 1, 0, 0, "R3 pop to empty top");
    do_op(1, 6, 2, 0, "R7 copy from empty top");
    for (int k = 0; k < 9; k++) do_op(1, 0, 0, 64'h1000 + 64'(k), "R2 fill ring");
    for (int k = 0; k < 9; k++) do_op(1, 1, 0, 0, "R3 drain ring");
    for (int k = 0; k < 400; k++)
      do_op($urandom_range(0, 7) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
            {$urandom(), $urandom()}, "R4 R9 R10 mixed ops");
    do_op(0, 0, 0, 0, "R10 final idle");
    done = 1;
    summary();
    $finish;
  end
endmodule